// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block is a memory-mapped interval timer. It requests an interrupt periodically, at a whole multiple of the clock cycle. A down-counter steps once per prescaled tick. The tick rate is set by an 8-bit scale value, and a tick fires every scale+1 enabled cycles. When a tick finds the counter already at zero, the block emits a one-cycle interrupt pulse and refills the counter from a reload period register. It does not decrement on that tick.

Software programs the block through a single-cycle register port. The port has a write strobe, a word address and write data. Read data is combinational and follows the address. A plain enable pin starts and stops counting. It stands in for a mode-status bit that lives elsewhere in the chip. Masking, clearing, forcing and prioritising the request belong to an outside interrupt controller.

The register port has no valid/ready flow control. Every write is accepted in the cycle its strobe is high, and reads never stall. No back-pressure rules therefore apply.

Top module: `pit_timer`

## Requirements
- R1: Register map by word address: 0x3FFB is the scale register, 0x3FFC is the count register and 0x3FFD is the period register. A write strobe stores the write data into the addressed register at the clock edge. Reads return the register contents, and any other address reads as 0.
- R2: The scale register keeps only write-data bits 7:0. Bits 15:8 read back as 0 at the scale address, and writes to those bits are dropped.
- R3: While enabled, a tick occurs every scale+1 cycles. In the first enabled cycle after enable goes high, the prescale phase restarts from the scale value, so a scale of 0 ticks in that very cycle.
- R4: While enable is low, the count and the prescale phase hold their values, and no interrupt is raised.
- R5: A tick that finds the count nonzero lowers it by one.
- R6: A tick that finds the count at zero loads the count from the period register and raises the interrupt output for one cycle. That cycle is the one in which the count first shows the reloaded value.
- R7: Cycle 0 is the first cycle in which enable is seen high. The first interrupt is high in cycle (count+1)*(scale+1), where count is the value at enable. Later interrupts follow every (period+1)*(scale+1) cycles.
- R8: A count write takes effect at the next edge and overrides that cycle's tick. A scale write also restarts the prescale phase from the new value at that edge.
- R9: A period write does not disturb the running count. Its value is used at the next reload.
- R10: A synchronous reset clears all three registers and the prescale phase, and holds the interrupt output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_en | input | 1 | Counting enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 14 | Word address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The interval formula is tried with random count, period and scale triples. It is also tried at the extremes: scale 255, and everything at zero, which gives an interrupt every cycle. These runs separate the first interval from the steady interval and catch off-by-one errors in either the prescaler or the zero-reload. Directed mid-run writes are made to count, scale and period. They show which writes act at once and which one waits for the reload. A pause with enable low, followed by a restart, shows that state is held and that the prescale phase restarts. Random register traffic, including a wide write to the scale address, checks the address decode and the dropped upper bits.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int ADDR_W = 14;
  localparam logic [ADDR_W-1:0] A_SCALE  = 14'h3FFB;
  localparam logic [ADDR_W-1:0] A_COUNT  = 14'h3FFC;
  localparam logic [ADDR_W-1:0] A_PERIOD = 14'h3FFD;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_SCALE,
    SEL_COUNT,
    SEL_PERIOD
  } reg_sel_e;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int SW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [CW-1:0]     count_q,
  output logic [CW-1:0]     period_q,
  output logic [SW-1:0]     scale_q,
  output logic              cnt_wr,
  output logic [CW-1:0]     cnt_wdata,
  output logic              scale_wr,
  output logic [SW-1:0]     scale_wdata,
  output logic [DW-1:0]     rdata
);
  reg_sel_e sel;

  always_comb begin
    case (addr)
      A_SCALE:  sel = SEL_SCALE;
      A_COUNT:  sel = SEL_COUNT;
      A_PERIOD: sel = SEL_PERIOD;
      default:  sel = SEL_NONE;
    endcase
  end

  assign cnt_wr      = wr_en && (sel == SEL_COUNT);
  assign scale_wr    = wr_en && (sel == SEL_SCALE);
  assign cnt_wdata   = wdata[CW-1:0];
  assign scale_wdata = wdata[SW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      scale_q  <= '0;
    end else begin
      if (wr_en && sel == SEL_PERIOD) period_q <= wdata[CW-1:0];
      if (scale_wr) scale_q <= scale_wdata;
    end
  end

  always_comb begin
    case (sel)
      SEL_SCALE:  rdata = DW'(scale_q);
      SEL_COUNT:  rdata = DW'(count_q);
      SEL_PERIOD: rdata = DW'(period_q);
      default:    rdata = '0;
    endcase
  end

  AST_PERIOD_STORE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_PERIOD) |=> (period_q == $past(wdata[CW-1:0]))); // R1
  AST_SCALE_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_SCALE) |=> (scale_q == $past(wdata[SW-1:0]))); // R2
endmodule

// File: rtl/pit_prescale.sv
module pit_prescale #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [SW-1:0] scale,
  input  logic          scale_wr,
  input  logic [SW-1:0] scale_nxt,
  output logic          tick
);
  logic [SW-1:0] phase;
  logic [SW-1:0] phase_cur;
  logic          en_q;

  assign phase_cur = (en && !en_q) ? scale : phase;
  assign tick      = en && (phase_cur == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= en;
      if (scale_wr)  phase <= scale_nxt;
      else if (tick) phase <= scale;
      else if (en)   phase <= phase_cur - 1'b1;
    end
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !scale_wr) |=> $stable(phase)); // R4
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && scale != '0 && !scale_wr) |=> !tick); // R3
endmodule

// File: rtl/pit_count.sv
module pit_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] count,
  output logic          irq
);
  logic at_zero;
  assign at_zero = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (cnt_wr) begin
        count <= cnt_wdata;
      end else if (tick) begin
        if (at_zero) begin
          count <= period;
          irq   <= 1'b1;
        end else begin
          count <= count - 1'b1;
        end
      end
    end
  end

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_wr) |=> ($stable(count) && !irq)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && count != '0) |=> (count == $past(count) - 1'b1)); // R5
  AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && count == '0) |=> (irq && count == $past(period))); // R6
  AST_COUNT_WRITE: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (count == $past(cnt_wdata) && !irq)); // R8
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int SW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tmr_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_pulse
);
  logic [CW-1:0] count_q;
  logic [CW-1:0] period_q;
  logic [SW-1:0] scale_q;
  logic          cnt_wr;
  logic [CW-1:0] cnt_wdata;
  logic          scale_wr;
  logic [SW-1:0] scale_wdata;
  logic          tick;

  pit_regs #(.DW(DW), .CW(CW), .SW(SW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .count_q(count_q), .period_q(period_q), .scale_q(scale_q),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .scale_wr(scale_wr),
    .scale_wdata(scale_wdata), .rdata(bus_rdata)
  );

  pit_prescale #(.SW(SW)) u_pre (
    .clk(clk), .rst(rst), .en(tmr_en), .scale(scale_q),
    .scale_wr(scale_wr), .scale_nxt(scale_wdata), .tick(tick)
  );

  pit_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .period(period_q), .count(count_q), .irq(irq_pulse)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_pulse && count_q == '0)); // R10
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(tmr_en)); // R4
endmodule

// File: tb/pit_timer_tb.sv
module pit_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [13:0] A_SC = 14'h3FFB;
  localparam logic [13:0] A_CN = 14'h3FFC;
  localparam logic [13:0] A_PE = 14'h3FFD;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tmr_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [13:0] bus_addr = A_CN;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_pulse;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pit_timer u_dut (
    .clk(clk), .rst(rst), .tmr_en(tmr_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int first_irq(input int c, input int s);
    return (c + 1) * (s + 1);
  endfunction

  function automatic int interval(input int p, input int s);
    return (p + 1) * (s + 1);
  endfunction

  task automatic wr(input logic [13:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = A_CN;
  endtask

  task automatic rd(input logic [13:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic run_timer(input int c, input int s, input int p, input string tag);
    int n1, n2, expc, v;
    wr(A_SC, 16'(s)); wr(A_PE, 16'(p)); wr(A_CN, 16'(c));
    n1 = first_irq(c, s);
    n2 = n1 + interval(p, s);
    @(negedge clk);
    tmr_en = 1'b1;
    for (int m = 0; m <= n2; m++) begin
      if (m > 0) @(negedge clk);
      rd(A_CN, v);
      check(irq_pulse === ((m == n1) || (m == n2)), {tag, " R7 irq timing"}, int'(irq_pulse), int'((m == n1) || (m == n2)));
      if (m < n1) expc = c - m / (s + 1);
      else if (m < n2) expc = p - (m - n1) / (s + 1);
      else expc = p;
      check(v == expc, {tag, " R5 R6 count"}, v, expc);
    end
    tmr_en = 1'b0;
  endtask

  task automatic run_write(input int c, input int s, input int p, input int wm,
                           input logic [13:0] wa, input int wd, input int e1,
                           input int rv, input string tag);
    int v;
    wr(A_SC, 16'(s)); wr(A_PE, 16'(p)); wr(A_CN, 16'(c));
    @(negedge clk);
    tmr_en = 1'b1;
    for (int m = 0; m <= e1; m++) begin
      if (m > 0) @(negedge clk);
      bus_we = 1'b0; bus_addr = A_CN;
      rd(A_CN, v);
      check(irq_pulse === (m == e1), {tag, " irq"}, int'(irq_pulse), int'(m == e1));
      if (m == e1) check(v == rv, {tag, " reload value"}, v, rv);
      if (m == e1 - 1) check(v == 0, {tag, " zero before reload"}, v, 0);
      if (m == wm) begin
        bus_we = 1'b1; bus_addr = wa; bus_wdata = 16'(wd);
      end
    end
    tmr_en = 1'b0;
    bus_we = 1'b0; bus_addr = A_CN;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v;
    int model [3];
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    rd(A_SC, v); check(v == 0, "R10 scale after reset", v, 0);
    rd(A_CN, v); check(v == 0, "R10 count after reset", v, 0);
    rd(A_PE, v); check(v == 0, "R10 period after reset", v, 0);
    check(irq_pulse === 1'b0, "R10 irq after reset", int'(irq_pulse), 0);

    // R2 upper scale bits dropped
    wr(A_SC, 16'hABCD);
    rd(A_SC, v); check(v == 16'h00CD, "R2 scale upper bits", v, 16'h00CD);

    // R1 random register traffic with enable low
    model[0] = 'hCD; model[1] = 0; model[2] = 0;
    for (int i = 0; i < 40; i++) begin
      int k;
      logic [15:0] d;
      logic [13:0] a;
      k = int'($urandom_range(0, 3));
      d = 16'($urandom);
      a = (k == 0) ? A_SC : (k == 1) ? A_CN : (k == 2) ? A_PE : 14'h0123;
      wr(a, d);
      if (k == 0) model[0] = int'(d[7:0]);
      else if (k < 3) model[k] = int'(d);
      rd(A_SC, v); check(v == model[0], "R1 scale readback", v, model[0]);
      rd(A_CN, v); check(v == model[1], "R1 count readback", v, model[1]);
      rd(A_PE, v); check(v == model[2], "R1 period readback", v, model[2]);
      rd(14'h3FFA, v); check(v == 0, "R1 unmapped read", v, 0);
    end

    // R7 directed example and extremes, then random triples (R3 R5 R6)
    run_timer(5, 1, 5, "example");
    run_timer(0, 0, 0, "all zero");
    run_timer(0, 255, 0, "scale 255");
    run_timer(3, 0, 7, "first differs");
    for (int i = 0; i < 8; i++)
      run_timer(int'($urandom_range(0, 15)), int'($urandom_range(0, 6)),
                int'($urandom_range(0, 15)), "random");

    // R8 count write overrides, then counts on
    run_write(10, 0, 4, 2, A_CN, 3, 7, 4, "R8 count write");
    // R8 scale write restarts prescale phase
    run_write(1, 200, 9, 2, A_SC, 0, 5, 9, "R8 scale write");
    // R9 period write waits for reload
    run_write(4, 0, 2, 2, A_PE, 6, 5, 6, "R9 period write");

    // R4 hold while disabled, R3 restart on re-enable
    wr(A_SC, 16'd0); wr(A_PE, 16'd0); wr(A_CN, 16'd10);
    @(negedge clk); tmr_en = 1'b1;
    repeat (3) @(negedge clk);
    tmr_en = 1'b0;
    rd(A_CN, v); check(v == 7, "R4 count before pause", v, 7);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      rd(A_CN, v); check(v == 7, "R4 count held", v, 7);
      check(irq_pulse === 1'b0, "R4 no irq while held", int'(irq_pulse), 0);
    end
    tmr_en = 1'b1;
    @(negedge clk);
    rd(A_CN, v); check(v == 6, "R3 tick in first enabled cycle", v, 6);

    // R10 reset in the middle of a run
    wr(A_SC, 16'd3); wr(A_PE, 16'd9);
    repeat (4) @(negedge clk);
    rst = 1'b1; tmr_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    rd(A_SC, v); check(v == 0, "R10 scale cleared", v, 0);
    rd(A_CN, v); check(v == 0, "R10 count cleared", v, 0);
    rd(A_PE, v); check(v == 0, "R10 period cleared", v, 0);
    check(irq_pulse === 1'b0, "R10 irq low", int'(irq_pulse), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule